// File: doc/BRIEF.md
# Operand Forwarding Selection Unit

This block sits in the execute stage of an in-order pipeline. It decides, for each of the two ALU operands, where the operand value comes from. There are three possible sources: the value read from the register file during decode, the result held in the execute/memory pipeline register, or the result held in the memory/writeback pipeline register. The choice depends on which stage, if any, holds the most recent pending write to the register that the operand names.

The block compares the two source register numbers now in execute against the destination register number and write flag of each later stage. It produces one 2-bit select per operand. The three-way operand multiplexers are included, so the block returns the resolved operands in the same cycle as the selects. All logic is combinational and adds no latency. Stalling for load-use cases and branch handling are the job of other blocks.

Top module: `fwd_unit`

## Requirements
- R1: Each select uses this encoding: 2'b00 takes the register-file value, 2'b10 takes the execute/memory result and 2'b01 takes the memory/writeback result. The value 2'b11 never appears.
- R2: An operand takes the execute/memory result when all three of these hold: that stage's write flag is 1, its destination is nonzero, and its destination equals the operand's source register.
- R3: An operand takes the memory/writeback result when all three of these hold for that stage (write flag is 1, destination is nonzero, destination equals the operand's source register) and the R2 condition is false for that same operand.
- R4: When both stages hold a write to the operand's source register, the execute/memory result is chosen, because it is the more recent producer.
- R5: A destination of register 0 never causes forwarding from either stage. A zero destination in execute/memory does not block a valid forward from memory/writeback.
- R6: A stage whose write flag is 0 never causes forwarding, even when its destination matches.
- R7: Operand A is resolved only against source register A and operand B only against source register B. The two selects are independent of each other.
- R8: Each resolved operand equals the source that its select names, in the same cycle as the inputs, with no register in between.
- R9: In a chain where both later stages write the register that both operands read, both selects are 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a | input | 5 | Source register number for operand A in execute |
| src_b | input | 5 | Source register number for operand B in execute |
| exm_wr | input | 1 | Write flag of the instruction in execute/memory |
| exm_rd | input | 5 | Destination register of the instruction in execute/memory |
| mwb_wr | input | 1 | Write flag of the instruction in memory/writeback |
| mwb_rd | input | 5 | Destination register of the instruction in memory/writeback |
| rf_a | input | 32 | Register-file value read for operand A |
| rf_b | input | 32 | Register-file value read for operand B |
| exm_res | input | 32 | Result held in execute/memory |
| mwb_res | input | 32 | Result held in memory/writeback |
| sel_a | output | 2 | Source select for operand A |
| sel_b | output | 2 | Source select for operand B |
| opnd_a | output | 32 | Resolved operand A |
| opnd_b | output | 32 | Resolved operand B |

## Verification
The hardest cases to bring about are those in which the two conditions interact. One is a double hit, where both stages match and the newer stage must win. Another is a destination of zero in execute/memory that matches, which must not shadow a valid memory/writeback match. A third is a match in the opposite operand, which must leave this operand alone. The stimulus reaches all of these with an exhaustive sweep. Register numbers are drawn from a small set that includes zero, and every write-flag pairing is used, so every overlap of matches occurs. A directed table adds the triple-chain case and the highest register number.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    localparam int REG_IDX_W = 5;
    localparam int WORD_W    = 32;
    localparam int NUM_OPS   = 2;

    // Select encoding; values are fixed because the operand mux decodes them
    typedef enum logic [1:0] {
        SRC_REGFILE = 2'b00,
        SRC_MEMWB   = 2'b01,
        SRC_EXMEM   = 2'b10
    } src_sel_e;

    // Priority resolution: the newer stage wins
    function automatic src_sel_e pick_source(input logic hit_newer, input logic hit_older);
        if (hit_newer)      return SRC_EXMEM;
        else if (hit_older) return SRC_MEMWB;
        else                return SRC_REGFILE;
    endfunction

endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
    parameter int IDX_W = fwd_pkg::REG_IDX_W
) (
    input  logic             prod_wr,
    input  logic [IDX_W-1:0] prod_rd,
    input  logic [IDX_W-1:0] cons_src,
    output logic             hit
);
    localparam logic [IDX_W-1:0] ZERO_REG = '0;

    always_comb begin
        hit = prod_wr && (prod_rd != ZERO_REG) && (prod_rd == cons_src);
    end
endmodule

// File: rtl/fwd_select.sv
module fwd_select (
    input  logic               hit_exm,
    input  logic               hit_mwb,
    output fwd_pkg::src_sel_e  sel
);
    always_comb begin
        sel = fwd_pkg::pick_source(hit_exm, hit_mwb);
    end
endmodule

// File: rtl/fwd_operand_mux.sv
module fwd_operand_mux #(
    parameter int DW = fwd_pkg::WORD_W
) (
    input  fwd_pkg::src_sel_e sel,
    input  logic [DW-1:0]     from_rf,
    input  logic [DW-1:0]     from_exm,
    input  logic [DW-1:0]     from_mwb,
    output logic [DW-1:0]     value
);
    always_comb begin
        unique case (sel)
            fwd_pkg::SRC_EXMEM: value = from_exm;
            fwd_pkg::SRC_MEMWB: value = from_mwb;
            default:            value = from_rf;
        endcase
    end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit #(
    parameter int IDX_W = fwd_pkg::REG_IDX_W,
    parameter int DW    = fwd_pkg::WORD_W
) (
    input  logic [IDX_W-1:0] src_a,
    input  logic [IDX_W-1:0] src_b,
    input  logic             exm_wr,
    input  logic [IDX_W-1:0] exm_rd,
    input  logic             mwb_wr,
    input  logic [IDX_W-1:0] mwb_rd,
    input  logic [DW-1:0]    rf_a,
    input  logic [DW-1:0]    rf_b,
    input  logic [DW-1:0]    exm_res,
    input  logic [DW-1:0]    mwb_res,
    output logic [1:0]       sel_a,
    output logic [1:0]       sel_b,
    output logic [DW-1:0]    opnd_a,
    output logic [DW-1:0]    opnd_b
);
    import fwd_pkg::*;

    localparam int OPS = fwd_pkg::NUM_OPS;
    localparam logic [IDX_W-1:0] ZERO_REG = '0;

    logic [IDX_W-1:0] src_v  [OPS];
    logic [DW-1:0]    rf_v   [OPS];
    logic [DW-1:0]    out_v  [OPS];
    src_sel_e         sel_v  [OPS];
    logic             hit_e  [OPS];
    logic             hit_m  [OPS];

    assign src_v[0] = src_a;
    assign src_v[1] = src_b;
    assign rf_v[0]  = rf_a;
    assign rf_v[1]  = rf_b;

    for (genvar i = 0; i < OPS; i++) begin : g_op
        fwd_match #(.IDX_W(IDX_W)) u_match_exm (
            .prod_wr (exm_wr),
            .prod_rd (exm_rd),
            .cons_src(src_v[i]),
            .hit     (hit_e[i])
        );

        fwd_match #(.IDX_W(IDX_W)) u_match_mwb (
            .prod_wr (mwb_wr),
            .prod_rd (mwb_rd),
            .cons_src(src_v[i]),
            .hit     (hit_m[i])
        );

        fwd_select u_sel (
            .hit_exm(hit_e[i]),
            .hit_mwb(hit_m[i]),
            .sel    (sel_v[i])
        );

        fwd_operand_mux #(.DW(DW)) u_mux (
            .sel     (sel_v[i]),
            .from_rf (rf_v[i]),
            .from_exm(exm_res),
            .from_mwb(mwb_res),
            .value   (out_v[i])
        );

        // Checks on the final selects against the port-level producer state
        always_comb begin
            assert_sel_legal_R1: assert (sel_v[i] != 2'b11)
                else $error("illegal select on operand %0d", i);
            assert_exm_qualified_R2: assert (sel_v[i] != SRC_EXMEM
                    || (exm_wr && exm_rd != ZERO_REG && exm_rd == src_v[i]))
                else $error("unqualified exm forward on operand %0d", i);
            assert_mwb_qualified_R3: assert (sel_v[i] != SRC_MEMWB
                    || (mwb_wr && mwb_rd != ZERO_REG && mwb_rd == src_v[i]))
                else $error("unqualified mwb forward on operand %0d", i);
            assert_newer_wins_R4: assert (!(exm_wr && exm_rd != ZERO_REG && exm_rd == src_v[i])
                    || sel_v[i] == SRC_EXMEM)
                else $error("newer producer lost on operand %0d", i);
            assert_mux_follows_R8: assert (
                    (sel_v[i] == SRC_EXMEM   && out_v[i] == exm_res) ||
                    (sel_v[i] == SRC_MEMWB   && out_v[i] == mwb_res) ||
                    (sel_v[i] == SRC_REGFILE && out_v[i] == rf_v[i]))
                else $error("operand %0d does not follow select", i);
        end
    end

    assign sel_a  = sel_v[0];
    assign sel_b  = sel_v[1];
    assign opnd_a = out_v[0];
    assign opnd_b = out_v[1];

endmodule

// File: tb/fwd_unit_bench.sv
module fwd_unit_bench;
    localparam int AW = 5;
    localparam int DW = 32;
    localparam logic [DW-1:0] V_RFA = 32'hAAAA_0001;
    localparam logic [DW-1:0] V_RFB = 32'hBBBB_0002;
    localparam logic [DW-1:0] V_EXM = 32'hEEEE_0003;
    localparam logic [DW-1:0] V_MWB = 32'h7777_0004;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;   // 250 MHz

    logic [AW-1:0] src_a, src_b, exm_rd, mwb_rd;
    logic          exm_wr, mwb_wr;
    logic [DW-1:0] rf_a, rf_b, exm_res, mwb_res;
    logic [1:0]    sel_a, sel_b;
    logic [DW-1:0] opnd_a, opnd_b;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    fwd_unit u_fwd_unit (
        .src_a(src_a), .src_b(src_b),
        .exm_wr(exm_wr), .exm_rd(exm_rd),
        .mwb_wr(mwb_wr), .mwb_rd(mwb_rd),
        .rf_a(rf_a), .rf_b(rf_b),
        .exm_res(exm_res), .mwb_res(mwb_res),
        .sel_a(sel_a), .sel_b(sel_b),
        .opnd_a(opnd_a), .opnd_b(opnd_b)
    );

    // src, src, ewr, erd, mwr, mrd, exp_a, exp_b
    localparam int NV = 12;
    localparam logic [25:0] VEC [NV] = '{
        {5'd1,  5'd2,  1'b1, 5'd1,  1'b0, 5'd0,  2'b10, 2'b00},
        {5'd1,  5'd2,  1'b1, 5'd2,  1'b0, 5'd0,  2'b00, 2'b10},
        {5'd1,  5'd2,  1'b0, 5'd0,  1'b1, 5'd1,  2'b01, 2'b00},
        {5'd1,  5'd2,  1'b0, 5'd0,  1'b1, 5'd2,  2'b00, 2'b01},
        {5'd1,  5'd1,  1'b1, 5'd1,  1'b1, 5'd1,  2'b10, 2'b10},
        {5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 5'd0,  2'b00, 2'b00},
        {5'd3,  5'd3,  1'b0, 5'd3,  1'b0, 5'd3,  2'b00, 2'b00},
        {5'd4,  5'd5,  1'b1, 5'd4,  1'b1, 5'd5,  2'b10, 2'b01},
        {5'd4,  5'd5,  1'b1, 5'd5,  1'b1, 5'd4,  2'b01, 2'b10},
        {5'd6,  5'd6,  1'b1, 5'd7,  1'b1, 5'd6,  2'b01, 2'b01},
        {5'd31, 5'd31, 1'b1, 5'd31, 1'b0, 5'd31, 2'b10, 2'b10},
        {5'd8,  5'd9,  1'b1, 5'd0,  1'b1, 5'd9,  2'b00, 2'b01}
    };

    function automatic string vec_tag(input int k);
        case (k)
            0, 10:   return "R2";
            2, 9:    return "R3";
            4:       return "R9";
            5, 11:   return "R5";
            6:       return "R6";
            default: return "R7";
        endcase
    endfunction

    function automatic logic [1:0] ref_sel(input logic [AW-1:0] s,
            input logic ew, input logic [AW-1:0] er,
            input logic mw, input logic [AW-1:0] mr);
        if (ew && er != 0 && er == s)      return 2'b10;
        else if (mw && mr != 0 && mr == s) return 2'b01;
        else                               return 2'b00;
    endfunction

    function automatic logic [DW-1:0] ref_val(input logic [1:0] s, input logic [DW-1:0] rf);
        case (s)
            2'b10:   return V_EXM;
            2'b01:   return V_MWB;
            default: return rf;
        endcase
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic apply(input logic [AW-1:0] sa, input logic [AW-1:0] sb,
            input logic ew, input logic [AW-1:0] er, input logic mw, input logic [AW-1:0] mr);
        @(negedge clk);
        src_a = sa; src_b = sb; exm_wr = ew; exm_rd = er; mwb_wr = mw; mwb_rd = mr;
        #1;
    endtask

    initial begin
        src_a = '0; src_b = '0; exm_wr = 1'b0; exm_rd = '0; mwb_wr = 1'b0; mwb_rd = '0;
        rf_a = V_RFA; rf_b = V_RFB; exm_res = V_EXM; mwb_res = V_MWB;
        repeat (3) @(posedge clk);
        #1;
        // reset-time state: nothing pending, register file chosen (R1)
        chk("R1 reset sel_a", {30'd0, sel_a}, 32'd0);
        chk("R1 reset sel_b", {30'd0, sel_b}, 32'd0);
        chk("R8 reset opnd_a", opnd_a, V_RFA);
        @(negedge clk) rst = 1'b0;

        // directed table
        for (int k = 0; k < NV; k++) begin
            apply(VEC[k][25:21], VEC[k][20:16], VEC[k][15], VEC[k][14:10],
                  VEC[k][9], VEC[k][8:4]);
            chk({vec_tag(k), " sel_a"}, {30'd0, sel_a}, {30'd0, VEC[k][3:2]});
            chk({vec_tag(k), " sel_b"}, {30'd0, sel_b}, {30'd0, VEC[k][1:0]});
            chk("R8 opnd_a", opnd_a, ref_val(VEC[k][3:2], V_RFA));
            chk("R8 opnd_b", opnd_b, ref_val(VEC[k][1:0], V_RFB));
        end

        // exhaustive sweep over registers {0..3} and all write-flag pairs (R4, R5, R6, R7)
        for (int code = 0; code < 1024; code++) begin
            logic [AW-1:0] sa, sb, er, mr;
            logic ew, mw;
            logic [1:0] ea, eb;
            sa = AW'(code[1:0]);
            sb = AW'(code[3:2]);
            er = AW'(code[5:4]);
            mr = AW'(code[7:6]);
            ew = code[8];
            mw = code[9];
            apply(sa, sb, ew, er, mw, mr);
            ea = ref_sel(sa, ew, er, mw, mr);
            eb = ref_sel(sb, ew, er, mw, mr);
            chk("R4 sweep sel_a", {30'd0, sel_a}, {30'd0, ea});
            chk("R7 sweep sel_b", {30'd0, sel_b}, {30'd0, eb});
            chk("R8 sweep opnd_a", opnd_a, ref_val(ea, V_RFA));
            chk("R8 sweep opnd_b", opnd_b, ref_val(eb, V_RFB));
        end

        // data change alone moves the operand in the same cycle (R8)
        apply(5'd1, 5'd2, 1'b1, 5'd1, 1'b1, 5'd2);
        @(negedge clk);
        exm_res = 32'h1234_5678; mwb_res = 32'h0BAD_F00D;
        #1;
        chk("R8 live exm", opnd_a, 32'h1234_5678);
        chk("R8 live mwb", opnd_b, 32'h0BAD_F00D);

        done = 1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog got=hang exp=finish");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule